// File: doc/BRIEF.md
# Two-Word Command Port Decoder

This block sits behind a 16-bit control port and a 16-bit data port. A control word whose two top bits are `10`, arriving while no command is pending, writes one of a small set of 8-bit internal registers. Any other control word opens a two-word command: the first word loads the low address bits and the low command-code bits and raises a pending flag. The next control word fills in the top address bits and the upper command-code bits and then closes the command.

When the completed command asks for DMA and DMA is enabled in the mode register, the decoder starts a transfer. The type of transfer comes from the two top bits of the source-high register. A fill is held armed and starts on the next accepted data-port write. A copy or external transfer starts at once. While a transfer runs, the decoder refuses writes on both ports and flags each refused write as busy. The `dma_done` input ends the transfer. The decoder never accesses memory itself.

Top module: `cpd_top`

## Requirements
- R1: After reset all registers read zero, and `addr`, `code`, `pending`, `dma_run` and `dma_start` are zero.
- R2: A control write with bits 15:14 = `10` and `pending` low writes bits 7:0 into register index bits 12:8 if that index is below `NUM_REGS`. An index at or above `NUM_REGS` changes nothing. A register write leaves `addr`, `code` and `pending` unchanged.
- R3: Any other control write with `pending` low sets `addr[13:0]` to word bits 13:0 and `code[1:0]` to word bits 15:14, keeps `addr[15:14]`, and sets `pending`.
- R4: A control write with `pending` high is always the second word, whatever its top bits. It sets `addr[15:14]` from word bits 1:0 and `code[5:2]` from word bits 7:4. It keeps the other bits, clears `pending` and leaves the registers untouched.
- R5: A second word with bit 7 set, sent while bit `DMA_EN_BIT` of register `MODE_IDX` is set and bits 7:6 of register `SRC_HI_IDX` are not `10`, raises `dma_start` for exactly the one cycle after its clock edge. `dma_kind` then equals those two bits (`11` copy, `0x` external transfer), and `dma_run` goes high.
- R6: If those source bits are `10`, the second word arms a fill and does not start a transfer. The next accepted data write raises `dma_start` with `dma_kind` = `10` and sets `dma_run`.
- R7: While `dma_run` is high, `ctl_busy` follows `ctl_wr` and `data_busy` follows `data_wr`. Refused writes change no state and are not accepted.
- R8: `data_accept` is high only for a data write while `dma_run` is low and `code[0]` is 1. A data write with `code[0]` = 0 is ignored and does not trigger an armed fill.
- R9: `dma_done` sampled high while `dma_run` is high clears `dma_run` on that edge.
- R10: No transfer starts or arms when the enable bit is clear or second-word bit 7 is clear. Each second word replaces any earlier fill arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_data | input | 16 | Control-port word |
| data_wr | input | 1 | Data-port write strobe |
| data_val | input | 16 | Data-port word (value passed to the memory side, unused here beyond gating) |
| dma_done | input | 1 | End of running transfer |
| ctl_busy | output | 1 | Control write refused |
| data_busy | output | 1 | Data write refused |
| data_accept | output | 1 | Data write accepted |
| data_out | output | 16 | Accepted data word |
| reg_file | output | NUM_REGS*8 | Register file, register i at bits i*8+7:i*8 |
| addr | output | 16 | Current address |
| code | output | 6 | Current command code |
| pending | output | 1 | First command word received |
| dma_start | output | 1 | One-cycle transfer launch |
| dma_kind | output | 2 | Type of the last launched transfer |
| dma_run | output | 1 | Transfer in progress |

## Verification
The bench sweeps every 5-bit register index, including the indices past the implemented count. A decoder that wraps or truncates the index would corrupt a low register. It sends second words whose top bits look like a register write; a decoder that checked the prefix before the pending flag would treat them as register writes. It checks that a fill waits for a data write and ignores one sent while `code[0]` is clear, and that a newer command without DMA disarms the fill. It also checks that writes during a transfer are refused and leave state unchanged, since a leaky gate would move the address while DMA owns it.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

  localparam int WORD_W = 16;
  localparam int IDX_W  = 5;
  localparam int CODE_W = 6;

  typedef enum logic [1:0] {
    KIND_EXT0 = 2'b00,
    KIND_EXT1 = 2'b01,
    KIND_FILL = 2'b10,
    KIND_COPY = 2'b11
  } dma_kind_e;

  function automatic logic f_is_reg_word(input logic [WORD_W-1:0] w);
    return w[15:14] == 2'b10;
  endfunction

  function automatic logic [WORD_W-1:0] f_first_addr(input logic [WORD_W-1:0] a,
                                                     input logic [WORD_W-1:0] w);
    return {a[15:14], w[13:0]};
  endfunction

  function automatic logic [CODE_W-1:0] f_first_code(input logic [CODE_W-1:0] c,
                                                     input logic [WORD_W-1:0] w);
    return {c[5:2], w[15:14]};
  endfunction

  function automatic logic [WORD_W-1:0] f_second_addr(input logic [WORD_W-1:0] a,
                                                      input logic [WORD_W-1:0] w);
    return {w[1:0], a[13:0]};
  endfunction

  function automatic logic [CODE_W-1:0] f_second_code(input logic [CODE_W-1:0] c,
                                                      input logic [WORD_W-1:0] w);
    return {w[7:4], c[1:0]};
  endfunction

endpackage

// File: rtl/cpd_ctl_decode.sv
module cpd_ctl_decode
  import cpd_pkg::*;
#(
  parameter int NUM_REGS = 24
) (
  input  logic              ctl_wr,
  input  logic [WORD_W-1:0] word,
  input  logic              pending,
  input  logic              running,
  output logic              reg_we,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [7:0]        reg_val,
  output logic              first_we,
  output logic              second_we
);
  logic taken;

  always_comb begin
    taken     = ctl_wr && !running;
    reg_idx   = word[12:8];
    reg_val   = word[7:0];
    second_we = taken && pending;
    first_we  = taken && !pending && !f_is_reg_word(word);
    reg_we    = taken && !pending && f_is_reg_word(word) &&
                (int'(reg_idx) < NUM_REGS);
  end
endmodule

// File: rtl/cpd_regfile.sv
module cpd_regfile
  import cpd_pkg::*;
#(
  parameter int NUM_REGS = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [IDX_W-1:0]      idx,
  input  logic [7:0]            val,
  output logic [NUM_REGS*8-1:0] flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                       q <= '0;
      else if (we && int'(idx) == i)    q <= val;
    end
    assign flat[i*8 +: 8] = q;
  end
endmodule

// File: rtl/cpd_cmd_state.sv
module cpd_cmd_state
  import cpd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first_we,
  input  logic              second_we,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] addr,
  output logic [CODE_W-1:0] code,
  output logic              pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= '0;
      code    <= '0;
      pending <= 1'b0;
    end else if (second_we) begin
      addr    <= f_second_addr(addr, word);
      code    <= f_second_code(code, word);
      pending <= 1'b0;
    end else if (first_we) begin
      addr    <= f_first_addr(addr, word);
      code    <= f_first_code(code, word);
      pending <= 1'b1;
    end
  end
endmodule

// File: rtl/cpd_dma_ctrl.sv
module cpd_dma_ctrl
  import cpd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      second_we,
  input  logic      dma_req,
  input  logic [1:0] src_sel,
  input  logic      data_taken,
  input  logic      dma_done,
  output logic      dma_start,
  output logic [1:0] dma_kind,
  output logic      dma_run
);
  logic armed;
  logic go_now;
  logic arm_fill;
  logic go_fill;

  assign go_now   = dma_req && (src_sel != KIND_FILL);
  assign arm_fill = dma_req && (src_sel == KIND_FILL);
  assign go_fill  = data_taken && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      dma_start <= 1'b0;
      dma_kind  <= KIND_EXT0;
      dma_run   <= 1'b0;
    end else begin
      dma_start <= 1'b0;
      if (dma_run && dma_done) dma_run <= 1'b0;
      if (go_now) begin
        dma_start <= 1'b1;
        dma_kind  <= src_sel;
        dma_run   <= 1'b1;
        armed     <= 1'b0;
      end else if (second_we) begin
        armed <= arm_fill;
      end else if (go_fill) begin
        dma_start <= 1'b1;
        dma_kind  <= KIND_FILL;
        dma_run   <= 1'b1;
        armed     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cpd_top.sv
module cpd_top
  import cpd_pkg::*;
#(
  parameter int NUM_REGS   = 24,
  parameter int MODE_IDX   = 1,
  parameter int DMA_EN_BIT = 4,
  parameter int SRC_HI_IDX = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_wr,
  input  logic [15:0]           ctl_data,
  input  logic                  data_wr,
  input  logic [15:0]           data_val,
  input  logic                  dma_done,
  output logic                  ctl_busy,
  output logic                  data_busy,
  output logic                  data_accept,
  output logic [15:0]           data_out,
  output logic [NUM_REGS*8-1:0] reg_file,
  output logic [15:0]           addr,
  output logic [5:0]            code,
  output logic                  pending,
  output logic                  dma_start,
  output logic [1:0]            dma_kind,
  output logic                  dma_run
);
  localparam int MODE_LSB = MODE_IDX * 8;
  localparam int SRC_LSB  = SRC_HI_IDX * 8;

  logic             reg_we;
  logic [IDX_W-1:0] reg_idx;
  logic [7:0]       reg_val;
  logic             first_we;
  logic             second_we;
  logic             dma_en;
  logic [1:0]       src_sel;
  logic             dma_req;

  cpd_ctl_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .ctl_wr   (ctl_wr),
    .word     (ctl_data),
    .pending  (pending),
    .running  (dma_run),
    .reg_we   (reg_we),
    .reg_idx  (reg_idx),
    .reg_val  (reg_val),
    .first_we (first_we),
    .second_we(second_we)
  );

  cpd_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (reg_we),
    .idx  (reg_idx),
    .val  (reg_val),
    .flat (reg_file)
  );

  cpd_cmd_state u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .first_we (first_we),
    .second_we(second_we),
    .word     (ctl_data),
    .addr     (addr),
    .code     (code),
    .pending  (pending)
  );

  assign dma_en  = reg_file[MODE_LSB + DMA_EN_BIT];
  assign src_sel = reg_file[SRC_LSB + 6 +: 2];
  assign dma_req = second_we && ctl_data[7] && dma_en;

  assign ctl_busy    = ctl_wr && dma_run;
  assign data_busy   = data_wr && dma_run;
  assign data_accept = data_wr && !dma_run && code[0];
  assign data_out    = data_accept ? data_val : '0;

  cpd_dma_ctrl u_dma (
    .clk       (clk),
    .rst_n     (rst_n),
    .second_we (second_we),
    .dma_req   (dma_req),
    .src_sel   (src_sel),
    .data_taken(data_accept),
    .dma_done  (dma_done),
    .dma_start (dma_start),
    .dma_kind  (dma_kind),
    .dma_run   (dma_run)
  );
endmodule

// File: rtl/cpd_checker.sv
module cpd_checker #(
  parameter int NUM_REGS = 24
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ctl_wr,
  input logic [15:0]           ctl_data,
  input logic                  data_wr,
  input logic                  dma_done,
  input logic                  ctl_busy,
  input logic                  data_accept,
  input logic [NUM_REGS*8-1:0] reg_file,
  input logic [15:0]           addr,
  input logic [5:0]            code,
  input logic                  pending,
  input logic                  dma_start,
  input logic [1:0]            dma_kind,
  input logic                  dma_run
);
  a_r7_refused_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_busy |=> ($stable(addr) && $stable(code) && $stable(pending) && $stable(reg_file)));

  a_r4_second_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && ctl_wr && !ctl_busy) |=>
      (!pending && addr[13:0] == $past(addr[13:0]) && code[1:0] == $past(code[1:0])
       && $stable(reg_file)));

  a_r3_first_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && ctl_wr && !ctl_busy && ctl_data[15:14] != 2'b10) |=>
      (pending && addr[15:14] == $past(addr[15:14])));

  a_r2_reg_write_keeps_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && ctl_wr && !ctl_busy && ctl_data[15:14] == 2'b10) |=>
      (!pending && $stable(addr) && $stable(code)));

  a_r2_high_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && ctl_wr && ctl_data[15:14] == 2'b10 && int'(ctl_data[12:8]) >= NUM_REGS)
      |=> $stable(reg_file));

  a_r6_fill_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_start && dma_kind == 2'b10) |-> $past(data_wr && data_accept));

  a_r5_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> dma_run);

  a_r8_read_mode_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !code[0]) |-> !data_accept);

  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_run && dma_done) |=> !dma_run);
endmodule

bind cpd_top cpd_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .ctl_data   (ctl_data),
  .data_wr    (data_wr),
  .dma_done   (dma_done),
  .ctl_busy   (ctl_busy),
  .data_accept(data_accept),
  .reg_file   (reg_file),
  .addr       (addr),
  .code       (code),
  .pending    (pending),
  .dma_start  (dma_start),
  .dma_kind   (dma_kind),
  .dma_run    (dma_run)
);

// File: tb/cpd_top_tb.sv
module cpd_top_tb;
  localparam int NR = 24;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ctl_wr = 1'b0;
  logic [15:0]     ctl_data = '0;
  logic            data_wr = 1'b0;
  logic [15:0]     data_val = '0;
  logic            dma_done = 1'b0;
  logic            ctl_busy, data_busy, data_accept;
  logic [15:0]     data_out;
  logic [NR*8-1:0] reg_file;
  logic [15:0]     addr;
  logic [5:0]      code;
  logic            pending, dma_start, dma_run;
  logic [1:0]      dma_kind;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0]  m_reg [NR];
  logic [15:0] m_addr = '0;
  logic [5:0]  m_code = '0;
  logic        s_busy, s_dbusy, s_acc;

  always #10 clk = ~clk;

  cpd_top u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .data_wr(data_wr), .data_val(data_val), .dma_done(dma_done),
    .ctl_busy(ctl_busy), .data_busy(data_busy), .data_accept(data_accept),
    .data_out(data_out), .reg_file(reg_file), .addr(addr), .code(code),
    .pending(pending), .dma_start(dma_start), .dma_kind(dma_kind), .dma_run(dma_run)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    logic [NR*8-1:0] e;
    for (int i = 0; i < NR; i++) e[i*8 +: 8] = m_reg[i];
    n_run++;
    if (reg_file !== e) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, reg_file, e);
    end
  endtask

  task automatic ctl(input logic [15:0] w);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_data = w;
    #1 s_busy = ctl_busy;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic dat(input logic [15:0] w);
    @(negedge clk);
    data_wr = 1'b1; data_val = w;
    #1 begin s_dbusy = data_busy; s_acc = data_accept; end
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  task automatic set_reg(input int idx, input logic [7:0] v);
    ctl(16'h8000 | 16'(idx << 8) | {8'h00, v});
    if (idx < NR) m_reg[idx] = v;
  endtask

  task automatic cmd(input logic [15:0] w1, input logic [15:0] w2);
    ctl(w1);
    m_addr = {m_addr[15:14], w1[13:0]};
    m_code = {m_code[5:2], w1[15:14]};
    ctl(w2);
    m_addr = {w2[1:0], m_addr[13:0]};
    m_code = {w2[7:4], m_code[1:0]};
  endtask

  task automatic finish_dma;
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
    chk("R9 run cleared by done", 32'(dma_run), 32'd0);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) m_reg[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_regs("R1 regs");
    chk("R1 addr", 32'(addr), 32'd0);
    chk("R1 code", 32'(code), 32'd0);
    chk("R1 pending", 32'(pending), 32'd0);
    chk("R1 run/start", {30'd0, dma_run, dma_start}, 32'd0);

    // R2 sweep of every 5-bit index (values keep DMA enable bit clear)
    for (int i = 0; i < 32; i++) begin
      set_reg(i, 8'((i * 37 + 5) & 8'hEF));
      chk_regs($sformatf("R2 idx %0d", i));
      chk("R2 pending stays low", {15'd0, pending, addr}, {16'd0, m_addr});
    end

    // R3/R4 command patterns, including second words that look like register writes
    for (int k = 0; k < 8; k++) begin
      logic [15:0] w1, w2;
      logic [1:0]  top;
      top = (k % 3 == 0) ? 2'b00 : (k % 3 == 1) ? 2'b01 : 2'b11;
      w1 = {top, 14'((k * 4913 + 77) & 16'h3FFF)};
      w2 = 16'(k * 16'h2345);
      ctl(w1);
      chk("R3 addr low/high kept", 32'(addr), 32'({m_addr[15:14], w1[13:0]}));
      chk("R3 code low", 32'(code), 32'({m_code[5:2], w1[15:14]}));
      chk("R3 pending set", 32'(pending), 32'd1);
      m_addr = {m_addr[15:14], w1[13:0]};
      m_code = {m_code[5:2], w1[15:14]};
      ctl(w2);
      m_addr = {w2[1:0], m_addr[13:0]};
      m_code = {w2[7:4], m_code[1:0]};
      chk("R4 addr", 32'(addr), 32'(m_addr));
      chk("R4 code", 32'(code), 32'(m_code));
      chk("R4 pending clear", 32'(pending), 32'd0);
      chk_regs("R4 regs untouched");
      chk("R10 no DMA while disabled", {30'd0, dma_run, dma_start}, 32'd0);
    end

    // R8 read-mode data write ignored, write-mode accepted
    cmd(16'h0000, 16'h0000);
    dat(16'h1234);
    chk("R8 ignored in read mode", 32'(s_acc), 32'd0);
    cmd(16'h4000, 16'h0000);
    dat(16'h5678);
    chk("R8 accepted in write mode", 32'(s_acc), 32'd1);

    // R5 copy
    set_reg(1, 8'h10);
    set_reg(23, 8'hC0);
    cmd(16'h4123, 16'h0082);
    chk("R5 copy start", {29'd0, dma_start, dma_kind}, {29'd0, 1'b1, 2'b11});
    chk("R5 run", 32'(dma_run), 32'd1);
    chk("R5 addr", 32'(addr), 32'(m_addr));
    @(negedge clk);
    chk("R5 start one cycle", 32'(dma_start), 32'd0);
    // R7 refused writes
    ctl(16'h3FFF);
    chk("R7 ctl busy", 32'(s_busy), 32'd1);
    chk("R7 no change", {9'd0, pending, code, addr}, {9'd0, 1'b0, m_code, m_addr});
    ctl(16'h8155);
    chk_regs("R7 reg write refused");
    dat(16'h0001);
    chk("R7 data busy/not accepted", {30'd0, s_dbusy, s_acc}, {30'd0, 2'b10});
    finish_dma();
    ctl(16'h4000);
    chk("R7 ctl free after done", 32'(s_busy), 32'd0);
    ctl(16'h0000);
    m_addr = {2'b00, 14'h0000}; m_code = 6'b000001;

    // R5 external transfer
    set_reg(23, 8'h40);
    cmd(16'h4001, 16'h00C3);
    chk("R5 external start", {29'd0, dma_start, dma_kind}, {29'd0, 1'b1, 2'b01});
    finish_dma();

    // R6 fill: armed, read-mode data write does not trigger
    set_reg(23, 8'h80);
    cmd(16'h0010, 16'h0080);
    chk("R6 fill not immediate", {30'd0, dma_run, dma_start}, 32'd0);
    dat(16'hAAAA);
    chk("R8 fill not triggered in read mode", {29'd0, s_acc, dma_run, dma_start}, 32'd0);
    cmd(16'h4010, 16'h0080);
    chk("R6 still waiting", 32'(dma_run), 32'd0);
    dat(16'hBBBB);
    chk("R6 fill start on data", {29'd0, dma_start, dma_kind}, {29'd0, 1'b1, 2'b10});
    chk("R6 run", 32'(dma_run), 32'd1);
    finish_dma();

    // R10 rearm replaced by plain command
    cmd(16'h4010, 16'h0080);
    cmd(16'h4010, 16'h0000);
    dat(16'hCCCC);
    chk("R10 fill disarmed", {30'd0, dma_run, dma_start}, 32'd0);
    // R10 bit 7 clear with enable set
    set_reg(23, 8'hC0);
    cmd(16'h4000, 16'h0070);
    chk("R10 no start without bit7", {30'd0, dma_run, dma_start}, 32'd0);
    // R10 enable clear
    set_reg(1, 8'h00);
    cmd(16'h4000, 16'h00F0);
    chk("R10 no start when disabled", {30'd0, dma_run, dma_start}, 32'd0);
    chk("R4 final code", 32'(code), 32'(m_code));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule